// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter with Command Strobes

This block sits between a processor whose low address byte and data byte share one set of eight bidirectional lines and a set of synchronous memory and I/O targets. The processor raises an address strobe while the low address byte is on the shared lines. The block captures that byte and joins it with the dedicated high address byte. The result is a stable 16-bit address for the targets, held for the rest of the bus cycle while the shared lines carry data.

The block also turns the processor's space flag (0 selects memory, 1 selects I/O) and its active-low read and write lines into four separate active-low command strobes. These are memory read, memory write, I/O read and I/O write. The strobes, the error flag and the bus drive enable are registered, so they follow the inputs by one clock. Because the shared lines are bidirectional, the block models them as an input path, an output path and an output enable. It drives read data from the targets back onto the lines only while a read strobe is active.

Top module: `busdemux_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has all four strobes high, `cmd_err` low, `ad_oe` low, and the held low address byte cleared to 0x00. The low byte is visible on `addr_out[7:0]` while `ale` is low.
- R2: While `ale` is high, `addr_out[7:0]` equals `ad_in` in the same cycle, so capture is transparent.
- R3: While `ale` is low, `addr_out[7:0]` holds the value `ad_in` had at the last rising clock edge where `ale` was high. Changes on `ad_in` have no effect on it.
- R4: `addr_out[15:8]` always equals `hi_addr` with no delay.
- R5: `iom`=0, `rd_n`=0, `wr_n`=1 at a clock edge gives only `mem_rd_n` low after that edge.
- R6: `iom`=0, `rd_n`=1, `wr_n`=0 gives only `mem_wr_n` low after the edge.
- R7: `iom`=1 with `rd_n`=0, `wr_n`=1 gives only `io_rd_n` low. `iom`=1 with `rd_n`=1, `wr_n`=0 gives only `io_wr_n` low. At most one strobe is ever low.
- R8: `rd_n`=0 and `wr_n`=0 together at an edge give all strobes high and `cmd_err` high after the edge. Any other combination gives `cmd_err` low. With both lines high, no strobe asserts.
- R9: `ad_oe` is high exactly when `mem_rd_n` or `io_rd_n` is low. `ad_out` then equals `tgt_rdata`, and `ad_out` is 0x00 when `ad_oe` is low.
- R10: `tgt_wdata` always equals `ad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ale | input | 1 | Address strobe: the shared lines carry the low address byte |
| ad_in | input | 8 | Value seen on the shared address/data lines |
| ad_out | output | 8 | Value driven onto the shared lines during reads |
| ad_oe | output | 1 | Drive enable for the shared lines |
| hi_addr | input | 8 | Dedicated high address byte |
| iom | input | 1 | Space select: 0 memory, 1 I/O |
| rd_n | input | 1 | Processor read, active low |
| wr_n | input | 1 | Processor write, active low |
| addr_out | output | 16 | Demultiplexed address to targets |
| tgt_wdata | output | 8 | Write data to targets |
| tgt_rdata | input | 8 | Read data from targets |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| cmd_err | output | 1 | Read and write were both requested |

## Verification
The hardest case to reach from the ports is the hold of the captured low byte while the same lines keep changing underneath it. The bench first raises `ale` for one edge with a chosen byte. It then drops `ale` and walks `ad_in` through several unrelated data values across further edges. At each step it confirms that the low address stays at the captured byte while `tgt_wdata` follows the lines. The illegal read-plus-write case is reached by sweeping all eight combinations of space, read and write, each with fresh read data.

// File: rtl/busdemux_pkg.sv
// Shared types for the bus splitter: active-high command set and decode.
package busdemux_pkg;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } cmd_t;

    localparam cmd_t CMD_NONE = '{mem_rd: 1'b0, mem_wr: 1'b0, io_rd: 1'b0, io_wr: 1'b0};

    // Turns space flag and active-low read/write into one active command.
    // Both read and write low yields no command.
    function automatic cmd_t decode_cmd(input logic iom, input logic rd_n, input logic wr_n);
        cmd_t c;
        c = CMD_NONE;
        if (!rd_n && wr_n) begin
            if (iom) c.io_rd  = 1'b1;
            else     c.mem_rd = 1'b1;
        end else if (rd_n && !wr_n) begin
            if (iom) c.io_wr  = 1'b1;
            else     c.mem_wr = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/bd_addr_capture.sv
// Address capture: holds the low address byte taken from the shared lines
// while the address strobe is high and joins it with the high byte.
// Assumes the strobe is high for at least one rising clock edge per cycle.
module bd_addr_capture #(
    parameter int LO_W = 8,
    parameter int HI_W = 8,
    localparam int A_W = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic [LO_W-1:0] ad_in,
    input  logic [HI_W-1:0] hi_in,
    output logic [A_W-1:0]  addr
);

    logic [LO_W-1:0] lo_q;
    logic [LO_W-1:0] lo_view;

    // Hold register: refresh on every edge the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)   lo_q <= '0;
        else if (ale) lo_q <= ad_in;
    end

    // Transparent view: pass the lines through while the strobe is high.
    always_comb begin
        lo_view = ale ? ad_in : lo_q;
    end

    // Address assembly: high byte straight through, low byte from the view.
    always_comb begin
        addr = {hi_in, lo_view};
    end

    // Held byte must not move across two consecutive strobe-low cycles.
    assert_lo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(!ale) && $past(rst_n)) |-> $stable(addr[LO_W-1:0]));

endmodule

// File: rtl/bd_strobe_decode.sv
// Strobe decoder: registers one active command from space/read/write and
// flags simultaneous read and write. Outputs lag the inputs by one clock.
module bd_strobe_decode
    import busdemux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iom,
    input  logic rd_n,
    input  logic wr_n,
    output cmd_t cmd,
    output logic err
);

    // Command register: decode inputs each edge, clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd <= CMD_NONE;
        else        cmd <= decode_cmd(iom, rd_n, wr_n);
    end

    // Error register: set while read and write are requested together.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= !rd_n && !wr_n;
    end

    assert_mem_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!iom && !rd_n && wr_n)) |-> (cmd.mem_rd && !cmd.mem_wr && !cmd.io_rd && !cmd.io_wr));

    assert_mem_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!iom && rd_n && !wr_n)) |-> (cmd.mem_wr && !cmd.mem_rd && !cmd.io_rd && !cmd.io_wr));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd.mem_rd, cmd.mem_wr, cmd.io_rd, cmd.io_wr}));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cmd == CMD_NONE));

endmodule

// File: rtl/bd_data_steer.sv
// Data steering: forwards the shared lines to the targets and returns
// target read data onto the shared lines only during a read command.
module bd_data_steer #(
    parameter int D_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_active,
    input  logic [D_W-1:0] ad_in,
    input  logic [D_W-1:0] rdata,
    output logic [D_W-1:0] ad_out,
    output logic           ad_oe,
    output logic [D_W-1:0] wdata
);

    // Output path: drive read data only when enabled, zero otherwise.
    always_comb begin
        ad_oe  = rd_active;
        ad_out = rd_active ? rdata : '0;
        wdata  = ad_in;
    end

    // Returned data must track the targets while the drive is on.
    assert_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (ad_out == rdata));

endmodule

// File: rtl/busdemux_top.sv
// Bus splitter top: address capture, strobe decode and data steering for a
// processor with a shared low-address/data bus. Strobes are active low.
module busdemux_top
    import busdemux_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8,
    localparam int A_W = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic [LO_W-1:0] ad_in,
    output logic [LO_W-1:0] ad_out,
    output logic            ad_oe,
    input  logic [HI_W-1:0] hi_addr,
    input  logic            iom,
    input  logic            rd_n,
    input  logic            wr_n,
    output logic [A_W-1:0]  addr_out,
    output logic [LO_W-1:0] tgt_wdata,
    input  logic [LO_W-1:0] tgt_rdata,
    output logic            mem_rd_n,
    output logic            mem_wr_n,
    output logic            io_rd_n,
    output logic            io_wr_n,
    output logic            cmd_err
);

    cmd_t cmd;
    logic rd_active;

    bd_addr_capture #(.LO_W(LO_W), .HI_W(HI_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in),
        .hi_in(hi_addr), .addr(addr_out)
    );

    bd_strobe_decode u_dec (
        .clk(clk), .rst_n(rst_n), .iom(iom), .rd_n(rd_n), .wr_n(wr_n),
        .cmd(cmd), .err(cmd_err)
    );

    // Read activity: either read command enables the return path.
    always_comb begin
        rd_active = cmd.mem_rd || cmd.io_rd;
    end

    bd_data_steer #(.D_W(LO_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .ad_in(ad_in),
        .rdata(tgt_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .wdata(tgt_wdata)
    );

    // Strobe outputs: invert the active-high command to active-low pins.
    always_comb begin
        mem_rd_n = !cmd.mem_rd;
        mem_wr_n = !cmd.mem_wr;
        io_rd_n  = !cmd.io_rd;
        io_wr_n  = !cmd.io_wr;
    end

endmodule

// File: tb/busdemux_top_test.sv
module busdemux_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ale;
    logic [7:0]  ad_in;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  hi_addr;
    logic        iom, rd_n, wr_n;
    logic [15:0] addr_out;
    logic [7:0]  tgt_wdata, tgt_rdata;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, cmd_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    busdemux_top uut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .hi_addr(hi_addr), .iom(iom), .rd_n(rd_n), .wr_n(wr_n),
        .addr_out(addr_out), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; ale = 1'b0; ad_in = 8'h5A; hi_addr = 8'h20;
        iom = 1'b0; rd_n = 1'b0; wr_n = 1'b1; tgt_rdata = 8'hC3;
        repeat (3) @(negedge clk);
        // R1: reset state even with a read requested on the inputs
        chk("R1 strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
        chk("R1 err", cmd_err, 0);
        chk("R1 oe", ad_oe, 0);
        chk("R1 lo addr", addr_out[7:0], 8'h00);
        rd_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R3/R4/R10: capture then hold while lines carry data
        for (int i = 0; i < 6; i++) begin
            logic [7:0] lo;
            lo = 8'(i * 37 + 5);
            hi_addr = 8'(8'hF0 - i * 19);
            ale = 1'b1; ad_in = lo;
            #1;
            chk("R2 transparent", addr_out[7:0], lo);
            chk("R4 high byte", addr_out[15:8], hi_addr);
            @(negedge clk);
            ale = 1'b0;
            for (int k = 0; k < 4; k++) begin
                ad_in = 8'(~lo + k * 53);
                #1;
                chk("R3 hold", addr_out[7:0], lo);
                chk("R10 wdata", tgt_wdata, ad_in);
                @(negedge clk);
                chk("R3 hold after edge", addr_out[7:0], lo);
            end
        end

        // R5-R9: all eight space/read/write combinations
        for (int c = 0; c < 8; c++) begin
            logic e_mr, e_mw, e_ir, e_iw, e_err, e_oe;
            iom = c[2]; rd_n = c[1]; wr_n = c[0];
            tgt_rdata = 8'(c * 29 + 17);
            e_mr  = !iom && !rd_n && wr_n;
            e_mw  = !iom && rd_n && !wr_n;
            e_ir  = iom && !rd_n && wr_n;
            e_iw  = iom && rd_n && !wr_n;
            e_err = !rd_n && !wr_n;
            e_oe  = e_mr || e_ir;
            @(negedge clk);
            chk("R5 mem_rd_n", mem_rd_n, !e_mr);
            chk("R6 mem_wr_n", mem_wr_n, !e_mw);
            chk("R7 io_rd_n", io_rd_n, !e_ir);
            chk("R7 io_wr_n", io_wr_n, !e_iw);
            chk("R8 err", cmd_err, e_err);
            chk("R9 oe", ad_oe, e_oe);
            chk("R9 ad_out", ad_out, e_oe ? tgt_rdata : 8'h00);
        end

        // R9: read data change while read held is returned at once
        iom = 1'b1; rd_n = 1'b0; wr_n = 1'b1;
        @(negedge clk);
        tgt_rdata = 8'hA7;
        #1;
        chk("R9 follow", ad_out, 8'hA7);

        done = 1'b1;
        summary();
    end

endmodule